// File: doc/BRIEF.md
# Successive approximation register controller

This block sequences a 10-bit successive-approximation conversion. An external DAC is driven by the block's parallel code, and an external comparator reports whether the DAC output sits above the analog input. The block runs a bisection search over the code space. Each bit is tried in turn from the most significant downwards, and the comparator verdict decides whether that bit is kept. When the search ends, the code on the output equals the converted value.

Internally a one-hot marker register selects the bit under trial. A decision register holds the verdicts gathered so far. The code driven out is the bitwise OR of the two. The marker moves on the rising clock edge. The decision register captures on the falling edge, so the DAC and comparator have half a period to settle on each trial code.

A user pulses `start` while the block is idle. The user then waits for `done` and reads `code`. The result stays on `code` until the next accepted start.

Top module: `sar_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is sampled on both clock edges, `code` is 0 and `done` is 0.
- R2: A `start` sampled high on a rising edge while idle begins a conversion. After that edge the marker holds bit 0 and the decision bits are cleared at the next falling edge. One rising edge later `code` equals 0x200, which is bit 9 alone.
- R3: Each trial lasts one clock cycle, and trials run from bit 9 down to bit 0. The trial code is the bits kept so far ORed with the bit under trial.
- R4: At each falling edge during a trial, the bit under trial is kept (set) if `cmp_hi` is 0 and dropped (cleared) if `cmp_hi` is 1. All other decision bits keep their values.
- R5: `done` is 0 during the ten trial cycles. It rises on the rising edge that ends the bit 0 trial, and `code` then equals the final result.
- R6: Once done, `code` and `done` hold their values regardless of `cmp_hi` until the next accepted start.
- R7: A `start` sampled while a conversion is in progress has no effect on the trial sequence or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; marker moves on the rising edge, decisions are taken on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a conversion, honoured only when idle |
| cmp_hi | input | 1 | Comparator verdict: 1 when the DAC output is above the analog input |
| code | output | 10 | Trial code to the DAC during conversion, final result afterwards |
| done | output | 1 | High from the end of a conversion until the next accepted start |

## Verification
A wrong marker state shows up at once as a wrong trial code. A bit that is skipped, repeated or doubled corrupts the value on `code` in the same cycle the trial begins. A wrong decision shows one cycle later, because the next trial code carries the kept bits. The bench follows a behavioural DAC and comparator for several input values, including the extremes and the mid-scale boundary. It compares every trial code and the final result against an independent bisection model, cycle by cycle. A sequencer that ends early or late is caught by `done` rising in the wrong cycle.

// File: rtl/sar_pkg.sv
// Package: shared constants for the successive-approximation controller.
// Assumes: consumers take the default width from here and may override it.
package sar_pkg;
    localparam int unsigned SAR_WIDTH = 10;
endpackage

// File: rtl/sar_marker.sv
// Module: sar_marker
// Walks a one-hot marker from the top bit down to bit 0, one place per
// rising edge. A load cycle parks the one in bit 0, and the first move
// rotates it into the top bit.
// Assumes: start is synchronous to clk; a start while busy is dropped.
module sar_marker #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [W-1:0] marker,
    output logic         loading,
    output logic         busy,
    output logic         done
);
    // Purpose: the block is busy from the load cycle to the last trial.
    assign busy = loading | (|marker);

    // Purpose: load, rotate or shift the marker and flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marker  <= '0;
            loading <= 1'b0;
            done    <= 1'b0;
        end else if (loading) begin
            marker  <= {marker[0], marker[W-1:1]};
            loading <= 1'b0;
        end else if (|marker) begin
            marker <= marker >> 1;
            if (marker[0]) begin
                done <= 1'b1;
            end
        end else if (start) begin
            marker  <= {{(W-1){1'b0}}, 1'b1};
            loading <= 1'b1;
            done    <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_decision.sv
// Module: sar_decision
// Captures the comparator verdict for the marked bit on the falling
// edge. It clears all bits in the load cycle.
// Assumes: mark is one-hot or zero and changes only on rising edges.
module sar_decision #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] mark,
    input  logic         cmp_hi,
    output logic [W-1:0] kept
);
    // Purpose: clear on load, else write the verdict into the marked bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            kept <= '0;
        end else if (clear) begin
            kept <= '0;
        end else begin
            kept <= (kept & ~mark) | (mark & {W{~cmp_hi}});
        end
    end
endmodule

// File: rtl/sar_merge.sv
// Module: sar_merge
// Forms the DAC code as the per-bit OR of the marker and the decisions.
// Assumes: both inputs are stable between their own clock edges.
module sar_merge #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH
) (
    input  logic [W-1:0] marker,
    input  logic [W-1:0] kept,
    output logic [W-1:0] code
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: one OR gate per code bit.
        assign code[i] = marker[i] | kept[i];
    end
endmodule

// File: rtl/sar_ctrl.sv
// Module: sar_ctrl (top)
// Successive-approximation sequencer. It drives an external DAC with
// trial codes and reads back an external comparator.
// Assumes: the DAC and comparator settle within half a clock period.
module sar_ctrl #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_hi,
    output logic [W-1:0] code,
    output logic         done
);
    logic [W-1:0] marker;
    logic [W-1:0] kept;
    logic         loading;
    logic         busy;

    sar_marker #(.W(W)) u_marker (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .marker  (marker),
        .loading (loading),
        .busy    (busy),
        .done    (done)
    );

    sar_decision #(.W(W)) u_decision (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (loading),
        .mark   (marker),
        .cmp_hi (cmp_hi),
        .kept   (kept)
    );

    sar_merge #(.W(W)) u_merge (
        .marker (marker),
        .kept   (kept),
        .code   (code)
    );
endmodule

// File: rtl/sar_ctrl_chk.sv
// Module: sar_ctrl_chk
// Temporal checks for sar_ctrl, attached with bind.
// Assumes: connected to the internal marker and decision signals.
module sar_ctrl_chk #(
    parameter int unsigned W = sar_pkg::SAR_WIDTH
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         cmp_hi,
    input logic [W-1:0] marker,
    input logic [W-1:0] kept,
    input logic         loading,
    input logic         busy,
    input logic [W-1:0] code,
    input logic         done
);
    // R2: an idle start loads bit 0 and flags the load cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (loading && marker == {{(W-1){1'b0}}, 1'b1}));

    // R2: the load cycle is followed by the top-bit trial
    a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> (marker == {1'b1, {(W-1){1'b0}}}));

    // R3: the marker never carries more than one bit
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(marker));

    // R3: trials move one place down per cycle
    a_r3_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loading && (|marker) && !marker[0]) |=> (marker == ($past(marker) >> 1)));

    // R4: the marked bit takes the inverted verdict, others keep theirs
    a_r4_decide: assert property (@(negedge clk) disable iff (!rst_n)
        (!loading && (|marker)) |=>
        (((kept & $past(marker)) == ($past(cmp_hi) ? '0 : $past(marker))) &&
         ((kept & ~$past(marker)) == ($past(kept) & ~$past(marker)))));

    // R5: the bit 0 trial ends with done and an empty marker
    a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (!loading && marker[0]) |=> (done && marker == '0));

    // R5: done is low throughout a conversion
    a_r5_done_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R6: idle without start keeps the code and done unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(code) && $stable(done)));

    // R7: a start while busy does not reload the marker
    a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !loading && start) |=> !loading);
endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmp_hi  (cmp_hi),
    .marker  (marker),
    .kept    (kept),
    .loading (loading),
    .busy    (busy),
    .code    (code),
    .done    (done)
);

// File: tb/tb_sar_ctrl.sv
`timescale 1ns/1ps
module tb_sar_ctrl;
    localparam int W = 10;

    typedef struct {
        logic [W-1:0] val;
        string        req;
        bit           last;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_hi;
    logic [W-1:0] code;
    logic         done;
    int           vin = 0;
    int           checks = 0;
    int           errors = 0;
    exp_t         exp_q[$];

    always #2 clk = ~clk;

    // behavioural DAC and comparator
    assign cmp_hi = (int'(code) > vin);

    sar_ctrl #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmp_hi (cmp_hi),
        .code   (code),
        .done   (done)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // driver: model the bisection, queue expectations, request a conversion
    task automatic run_conv(input int v, input string req, input bit poke);
        logic [W-1:0] res = '0;
        logic [W-1:0] trial;
        for (int b = W - 1; b >= 0; b--) begin
            exp_t e;
            trial = res | (W'(1) << b);
            e.val = trial; e.req = req; e.last = 1'b0;
            exp_q.push_back(e);
            if (!(int'(trial) > v)) res = trial;
        end
        begin
            exp_t f;
            f.val = res; f.req = "R5"; f.last = 1'b1;
            exp_q.push_back(f);
        end
        vin = v;
        start = 1'b1;
        @(posedge clk); #3;
        start = 1'b0;
        if (poke) begin
            repeat (4) @(posedge clk);
            #3 start = 1'b1;
            @(posedge clk); #3;
            start = 1'b0;
        end
        @(negedge clk);
        while (!done) @(negedge clk);
        #1;
    endtask

    // monitor: compare every trial and the final code as they appear
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            @(posedge clk);
            forever begin
                exp_t e;
                @(posedge clk); #1;
                e = exp_q.pop_front();
                check(e.req, code, e.val);
                check(e.last ? "R5" : "R5", W'(done), W'(e.last));
                if (e.last) break;
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1", code, '0);
        check("R1", W'(done), '0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", code, '0);

        // R2 R3 R4: mid-scale and extremes
        run_conv(512, "R2", 1'b0);
        run_conv(0, "R3", 1'b0);
        run_conv(1023, "R4", 1'b0);
        run_conv(511, "R4", 1'b0);
        // back-to-back start directly after done
        run_conv(341, "R3", 1'b0);
        // R7: start pulsed during a conversion
        run_conv(700, "R7", 1'b1);
        run_conv(1, "R7", 1'b1);

        // R6: the result holds while the input moves
        held = code;
        vin = 0;
        repeat (6) @(posedge clk);
        #1;
        check("R6", code, held);
        check("R6", W'(done), W'(1));
        vin = 1023;
        repeat (3) @(posedge clk);
        #1;
        check("R6", code, held);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule